// File: doc/BRIEF.md
# UART Modem-Control Loopback

This block is the loopback path of a UART. When the loopback-enable field of the control register is set, it feeds the four modem control outputs that software drives back onto the four modem status flags. It then rebuilds the modem-status interrupt group from the new flags. It also returns transmitted characters and newly requested breaks to the receive path as push requests.

The surrounding register file supplies the inputs. On a control write it presents the new loopback-enable value and the four modem control fields. On a data write it presents the transmit byte. On a line-control write it presents the new send-break bit. Each accepted write reaches the outputs one clock later. The flags are registered and hold their value between mirroring events. The interrupt clear and set outputs, and the receive push, are single-cycle pulses that the interrupt logic and the receive FIFO consume.

Top module: `mdm_loopback`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, `stat_o`, `ms_set_o` and `ms_clr_o` are 0 and `rx_push_o` is 0.
- R2: A control write with `ctrl_lbk_i`=1 sets `stat_o` in the next cycle as follows. The `ctrl_mdm_i` bits are [0]=DTR, [1]=RTS, [2]=Out1, [3]=Out2. The `stat_o` bits are [0]=CTS, [1]=DSR, [2]=RI, [3]=DCD. CTS copies RTS, DSR copies DTR, RI copies Out2 and DCD copies Out1. `stat_o` then holds until the next mirroring write.
- R3: A control write that turns loopback on from the off state mirrors in the same way as R2. No earlier write is needed.
- R4: In the cycle after a mirroring control write, `ms_clr_o` is 1 for exactly one cycle, which clears the whole modem interrupt group. In that same cycle `ms_set_o` equals the new `stat_o`, using the same bit positions.
- R5: A control write with `ctrl_lbk_i`=0 leaves `stat_o` unchanged and produces no `ms_clr_o` pulse. It also turns loopback off for the writes that follow.
- R6: With loopback on, a transmit write raises `rx_push_o` in the next cycle for one cycle. `rx_data_o` then equals the written byte and `rx_brk_o` is 0.
- R7: With loopback on, a line-control write that changes the send-break bit from 0 to 1 raises `rx_push_o` in the next cycle with `rx_brk_o`=1 and `rx_data_o`=0.
- R8: A line-control write that keeps the break bit at 1, or takes it from 1 to 0, pushes nothing. The break-bit history is tracked whether loopback is on or off.
- R9: With loopback off, transmit writes and break rises push nothing.
- R10: `ms_set_o` is 0 in every cycle where `ms_clr_o` is 0, and `rx_push_o` never stays high for two cycles from a single write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ctrl_we_i | input | 1 | control register write strobe |
| ctrl_lbk_i | input | 1 | new loopback-enable value |
| ctrl_mdm_i | input | 4 | new modem control fields (DTR, RTS, Out1, Out2) |
| tx_we_i | input | 1 | transmit data write strobe |
| tx_data_i | input | DATA_W | transmit byte |
| lcr_we_i | input | 1 | line-control write strobe |
| lcr_brk_i | input | 1 | new send-break bit |
| stat_o | output | 4 | modem status flags (CTS, DSR, RI, DCD) |
| ms_clr_o | output | 1 | clear pulse for the modem interrupt group |
| ms_set_o | output | 4 | modem interrupt bits to set with the clear |
| rx_push_o | output | 1 | receive FIFO push request |
| rx_data_o | output | DATA_W | character to push |
| rx_brk_o | output | 1 | pushed character is a break |

## Verification
The assertions assume that the register file issues at most one of the three write strobes in any cycle. Under that assumption each output pulse traces back to exactly one write. The bench keeps to this in its directed phases. In its pseudo-random phase it picks a single strobe per cycle from the random bits. The checker keeps its own copy of the loopback-enable and break history, which it builds from the write ports alone.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
  localparam int unsigned MDM_W = 4;
  // control bits: 0 dtr, 1 rts, 2 out1, 3 out2
  // status bits : 0 cts, 1 dsr, 2 ri, 3 dcd
  localparam int unsigned STAT_SRC [MDM_W] = '{1, 0, 3, 2};
endpackage

// File: rtl/mlb_status.sv
module mlb_status
  import mlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [MDM_W-1:0] ctl_i,
  output logic [MDM_W-1:0] stat_o,
  output logic             ms_clr_o,
  output logic [MDM_W-1:0] ms_set_o
);
  logic [MDM_W-1:0] mirror;
  logic [MDM_W-1:0] stat_q, set_q;
  logic             clr_q;

  for (genvar i = 0; i < MDM_W; i++) begin : g_map
    assign mirror[i] = ctl_i[STAT_SRC[i]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      clr_q  <= 1'b0;
      set_q  <= '0;
    end else begin
      clr_q <= 1'b0;
      set_q <= '0;
      if (upd_i) begin
        stat_q <= mirror;
        clr_q  <= 1'b1;
        set_q  <= mirror;
      end
    end
  end

  assign stat_o   = stat_q;
  assign ms_clr_o = clr_q;
  assign ms_set_o = set_q;
endmodule

// File: rtl/mlb_inject.sv
module mlb_inject #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lbk_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              lcr_we_i,
  input  logic              lcr_brk_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o,
  output logic              brk_o
);
  logic              brk_q;
  logic              brk_rise;
  logic              push_q, pbrk_q;
  logic [DATA_W-1:0] data_q;

  assign brk_rise = lcr_we_i & lcr_brk_i & ~brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q  <= 1'b0;
      push_q <= 1'b0;
      pbrk_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (lcr_we_i) brk_q <= lcr_brk_i;
      push_q <= 1'b0;
      pbrk_q <= 1'b0;
      data_q <= '0;
      if (lbk_i && brk_rise) begin
        push_q <= 1'b1;
        pbrk_q <= 1'b1;
      end else if (lbk_i && tx_we_i) begin
        push_q <= 1'b1;
        data_q <= tx_data_i;
      end
    end
  end

  assign push_o = push_q;
  assign data_o = data_q;
  assign brk_o  = pbrk_q;
endmodule

// File: rtl/mdm_loopback.sv
module mdm_loopback
  import mlb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ctrl_lbk_i,
  input  logic [3:0]        ctrl_mdm_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              lcr_we_i,
  input  logic              lcr_brk_i,
  output logic [3:0]        stat_o,
  output logic              ms_clr_o,
  output logic [3:0]        ms_set_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_brk_o
);
  logic lbk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lbk_q <= 1'b0;
    else if (ctrl_we_i) lbk_q <= ctrl_lbk_i;
  end

  mlb_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (ctrl_we_i & ctrl_lbk_i),
    .ctl_i    (ctrl_mdm_i),
    .stat_o   (stat_o),
    .ms_clr_o (ms_clr_o),
    .ms_set_o (ms_set_o)
  );

  mlb_inject #(.DATA_W(DATA_W)) u_inject (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lbk_i     (lbk_q),
    .tx_we_i   (tx_we_i),
    .tx_data_i (tx_data_i),
    .lcr_we_i  (lcr_we_i),
    .lcr_brk_i (lcr_brk_i),
    .push_o    (rx_push_o),
    .data_o    (rx_data_o),
    .brk_o     (rx_brk_o)
  );
endmodule

// File: rtl/mlb_chk.sv
module mlb_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic              ctrl_lbk_i,
  input logic [3:0]        ctrl_mdm_i,
  input logic              tx_we_i,
  input logic [DATA_W-1:0] tx_data_i,
  input logic              lcr_we_i,
  input logic              lcr_brk_i,
  input logic [3:0]        stat_o,
  input logic              ms_clr_o,
  input logic [3:0]        ms_set_o,
  input logic              rx_push_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_brk_o
);
  logic ref_lbk, ref_brk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_lbk <= 1'b0;
      ref_brk <= 1'b0;
    end else begin
      if (ctrl_we_i) ref_lbk <= ctrl_lbk_i;
      if (lcr_we_i)  ref_brk <= lcr_brk_i;
    end
  end

  // input assumption: one write strobe per cycle
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_we_i, tx_we_i, lcr_we_i}));

  // R2
  mirror_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && ctrl_lbk_i |=>
      stat_o == {$past(ctrl_mdm_i[2]), $past(ctrl_mdm_i[3]),
                 $past(ctrl_mdm_i[0]), $past(ctrl_mdm_i[1])});

  // R4
  ms_rebuild_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && ctrl_lbk_i |=> ms_clr_o && ms_set_o == stat_o);

  // R5
  no_mirror_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && !ctrl_lbk_i |=> !ms_clr_o && $stable(stat_o));

  // R6
  tx_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_we_i && ref_lbk |=> rx_push_o && !rx_brk_o && rx_data_o == $past(tx_data_i));

  // R7
  brk_inject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_we_i && lcr_brk_i && !ref_brk && ref_lbk |=> rx_push_o && rx_brk_o && rx_data_o == '0);

  // R8
  brk_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_we_i && !(lcr_brk_i && !ref_brk) |=> !rx_push_o);

  // R9
  off_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_we_i || lcr_we_i) && !ref_lbk |=> !rx_push_o);

  // R10
  set_needs_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ms_clr_o |-> ms_set_o == '0);

  // R10
  push_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |=> !rx_push_o || $past(tx_we_i || lcr_we_i));
endmodule

bind mdm_loopback mlb_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_we_i  (ctrl_we_i),
  .ctrl_lbk_i (ctrl_lbk_i),
  .ctrl_mdm_i (ctrl_mdm_i),
  .tx_we_i    (tx_we_i),
  .tx_data_i  (tx_data_i),
  .lcr_we_i   (lcr_we_i),
  .lcr_brk_i  (lcr_brk_i),
  .stat_o     (stat_o),
  .ms_clr_o   (ms_clr_o),
  .ms_set_o   (ms_set_o),
  .rx_push_o  (rx_push_o),
  .rx_data_o  (rx_data_o),
  .rx_brk_o   (rx_brk_o)
);

// File: tb/sim_mdm_loopback.sv
`timescale 1ns/1ps
module sim_mdm_loopback;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ctrl_we_i = 1'b0, ctrl_lbk_i = 1'b0;
  logic [3:0]    ctrl_mdm_i = '0;
  logic          tx_we_i = 1'b0;
  logic [DW-1:0] tx_data_i = '0;
  logic          lcr_we_i = 1'b0, lcr_brk_i = 1'b0;
  logic [3:0]    stat_o, ms_set_o;
  logic          ms_clr_o, rx_push_o, rx_brk_o;
  logic [DW-1:0] rx_data_o;

  always #5 clk_i = ~clk_i;

  mdm_loopback #(.DATA_W(DW)) u0 (.*);

  int errors = 0, checks = 0;
  string cur_req = "R1";

  // behavioural model state
  bit         m_lbk, m_brk;
  bit [3:0]   e_stat, e_set;
  bit         e_clr, e_push, e_brk;
  bit [DW-1:0] e_data;

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_step();
    e_clr = 0; e_set = 0; e_push = 0; e_brk = 0; e_data = 0;
    if (ctrl_we_i) begin
      m_lbk = ctrl_lbk_i;
      if (ctrl_lbk_i) begin
        e_stat = {ctrl_mdm_i[2], ctrl_mdm_i[3], ctrl_mdm_i[0], ctrl_mdm_i[1]};
        e_clr = 1; e_set = e_stat;
      end
    end
    if (tx_we_i && m_lbk) begin e_push = 1; e_data = tx_data_i; end
    if (lcr_we_i) begin
      if (lcr_brk_i && !m_brk && m_lbk) begin e_push = 1; e_brk = 1; end
      m_brk = lcr_brk_i;
    end
  endtask

  task automatic compare_all();
    cmp("stat_o", stat_o, e_stat);
    cmp("ms_clr_o", ms_clr_o, e_clr);
    cmp("ms_set_o", ms_set_o, e_set);
    cmp("rx_push_o", rx_push_o, e_push);
    if (e_push) begin
      cmp("rx_data_o", rx_data_o, e_data);
      cmp("rx_brk_o", rx_brk_o, e_brk);
    end
  endtask

  // one cycle: inputs already set at negedge
  task automatic cycle();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare_all();
    ctrl_we_i = 0; tx_we_i = 0; lcr_we_i = 0;
  endtask

  task automatic wr_ctrl(bit lbk, bit [3:0] mdm);
    ctrl_we_i = 1; ctrl_lbk_i = lbk; ctrl_mdm_i = mdm; cycle();
  endtask
  task automatic wr_tx(bit [DW-1:0] d);
    tx_we_i = 1; tx_data_i = d; cycle();
  endtask
  task automatic wr_lcr(bit b);
    lcr_we_i = 1; lcr_brk_i = b; cycle();
  endtask

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    cur_req = "R1";
    repeat (3) @(negedge clk_i);
    compare_all();
    rst_ni = 1;
    cycle();

    cur_req = "R5";
    wr_ctrl(0, 4'hF); cycle();

    cur_req = "R9";
    wr_tx(8'h5A); wr_lcr(1); cycle(); wr_lcr(0);

    cur_req = "R3";
    wr_ctrl(1, 4'b0101); cycle();

    cur_req = "R2";
    for (int v = 0; v < 16; v++) wr_ctrl(1, v[3:0]);

    cur_req = "R4";
    wr_ctrl(1, 4'b1000); cycle(); wr_ctrl(1, 4'b0010);

    cur_req = "R6";
    wr_tx(8'h00); wr_tx(8'hA5); cycle(); wr_tx(8'hFF);

    cur_req = "R7";
    wr_lcr(1); cycle();

    cur_req = "R8";
    wr_lcr(1); wr_lcr(0); wr_lcr(0); cycle();

    cur_req = "R7";
    wr_lcr(1);

    cur_req = "R5";
    wr_ctrl(0, 4'b1010); cycle();

    cur_req = "R9";
    wr_tx(8'h3C); wr_lcr(0); wr_lcr(1); cycle();

    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: begin ctrl_we_i = 1; ctrl_lbk_i = lfsr[2] | lfsr[3]; ctrl_mdm_i = lfsr[7:4]; end
        2'd1: begin tx_we_i = 1; tx_data_i = lfsr[15:8]; end
        2'd2: begin lcr_we_i = 1; lcr_brk_i = lfsr[5]; end
        default: ;
      endcase
      cycle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule